// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames into CPU memory through a ring of descriptors. Each frame arrives as a byte stream with start and end markers. A source-port tag and a few classification flags travel with the first byte. For every frame the block fetches the current descriptor over a single request/grant memory port. If the hardware owns that descriptor, the block writes the frame into its buffer four bytes per word. It then writes a packed status word and finally releases the descriptor to the CPU by clearing its ownership bit.

The ring has no fixed length. Descriptors are four consecutive words starting at a programmable base. After a descriptor whose end-of-ring flag is set, the next frame goes back to the base. If the current descriptor still belongs to the CPU when a frame starts, the whole frame is swallowed and an error pulse is raised. A frame that completes normally raises a done pulse.

Descriptor layout, in word offsets from the descriptor address:
- Word 0: ownership bit 31, end-of-ring bit 28, buffer byte address in bits 24:0.
- Word 1: second buffer, unused here.
- Word 2: buffer length limit in bits 10:0.
- Word 3: status.

Top module: `rxd_ring_writer`

## Requirements
- R1: A frame is stored only into a descriptor whose word 0 has bit 31 set. On release, word 0 is written back with bit 31 cleared and every other bit unchanged, including end-of-ring bit 28 and address bits 24:0.
- R2: If word 0 of the current descriptor has bit 31 clear when a frame starts, the frame is consumed with no memory write. `irq_nodesc` pulses for exactly one cycle, and the next frame uses the same descriptor.
- R3: After a released descriptor, the next descriptor is 4 words further on. If the released descriptor had bit 28 set, the next descriptor is back at the ring base.
- R4: Frame bytes are packed little-endian (first byte in bits 7:0) into consecutive words. Packing starts at word address = buffer byte address / 4. A final partial word has zeros in its unused upper bytes. While `s_ready` is high the block makes no memory request.
- R5: Bytes beyond the buffer length in word 2 bits 10:0 are discarded. The stored length is min(frame bytes, buffer length).
- R6: Status word 3 is laid out as follows, with all other bits zero:
  - bits 26:16: stored length, counting every stream byte including the 4 CRC bytes;
  - bits 14:12: source port;
  - bits 5:4: destination class;
  - bit 3: IP-checksum-failed flag;
  - bit 2: VLAN flag;
  - bits 1:0: packet type (0 IP, 1 PPPoE).
  The port, class, flags and type are those presented with the start-of-frame byte.
- R7: The status word is written before the word-0 release. `irq_done` is high for exactly one cycle, the cycle after the release write is granted.
- R8: After reset, `mem_req`, `s_ready`, `irq_done` and `irq_nodesc` are low, and the ring pointer and base are 0.
- R9: A `base_wr` pulse while idle sets both the ring base and the current descriptor to `base_addr`.
- R10: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_gnt`. Read data is taken from `mem_rdata` in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Load ring base (idle only) |
| base_addr | input | AW | Ring base, word address |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| s_data | input | 8 | Frame byte |
| s_port | input | 3 | Source port tag (with first byte) |
| s_da_class | input | 2 | Destination-address class (with first byte) |
| s_ip_bad | input | 1 | IP checksum failed (with first byte) |
| s_vlan | input | 1 | VLAN tag present (with first byte) |
| s_ptype | input | 2 | Packet type (with first byte) |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after grant |
| irq_done | output | 1 | One-cycle frame-released pulse |
| irq_nodesc | output | 1 | One-cycle no-descriptor pulse |

## Verification
The fetch of word 0 is granted no earlier than the cycle after a start byte is presented. A CPU-owned result shows on `irq_nodesc` two cycles after that grant. Each data word is requested in the cycle after its fourth byte (or the end byte) is taken. Status and release writes then follow back to back as grants allow, and `irq_done` is high exactly one cycle after the release grant. Because grants are randomly withheld, the scoreboard does not wait a fixed number of cycles. Instead it compares every granted write, done pulse and error pulse, in order, against a queue filled when each frame is queued. Each event is sampled between clock edges in the cycle it is due.

// File: rtl/rxd_pkg.sv
// Shared constants and types for the receive descriptor ring writer.
// Assumes 32-bit memory words and 4-word descriptors.
package rxd_pkg;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 28;
    localparam int BUF_ADDR_W = 25;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 11;
    localparam int PORT_LSB   = 12;
    localparam int DA_LSB     = 4;
    localparam int IPF_BIT    = 3;
    localparam int VLAN_BIT   = 2;
    localparam int OFS_BUF1   = 0;
    localparam int OFS_BLEN   = 2;
    localparam int OFS_STAT   = 3;
    localparam int DESC_WORDS = 4;

    typedef struct packed {
        logic [2:0] port;
        logic [1:0] da;
        logic       ipf;
        logic       vlan;
        logic [1:0] ptype;
    } rx_meta_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD0W, ST_RD2, ST_RD2W, ST_RECV,
        ST_WDAT, ST_WSTAT, ST_WOWN, ST_DONE, ST_DROP
    } wr_state_t;
endpackage

// File: rtl/rxd_ring.sv
// Ring pointer: holds the ring base and the current descriptor address.
// Steps by one descriptor, or returns to base when wrap is set.
// Assumes load is only asserted while the writer is idle.
module rxd_ring #(
    parameter int AW   = 12,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] base_q;

    // Base register and current pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur    <= '0;
        end else if (load) begin
            base_q <= load_addr;
            cur    <= load_addr;
        end else if (step) begin
            cur <= wrap ? base_q : cur + AW'(STEP);
        end
    end
endmodule

// File: rtl/rxd_pack.sv
// Byte-to-word packer: places each pushed byte in the next lane.
// Lane 0 is the low byte. Clear empties the word and zeroes all lanes.
// Assumes push and clear never coincide.
module rxd_pack #(
    parameter int BYTES = 4,
    localparam int CW   = $clog2(BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] word,
    output logic [CW-1:0]      fill
);
    // Count of occupied lanes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) fill <= '0;
        else if (push)       fill <= fill + 1'b1;
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // One byte lane, loaded when it is the next free lane.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)               word[8*g +: 8] <= '0;
            else if (push && fill == CW'(g))   word[8*g +: 8] <= din;
        end
    end
endmodule

// File: rtl/rxd_status_enc.sv
// Packs stored length and frame metadata into the status word.
// Pure combinational; unused bits are zero.
module rxd_status_enc
    import rxd_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  rx_meta_t         meta,
    output logic [31:0]      word
);
    // Field placement.
    always_comb begin
        word                    = '0;
        word[LEN_LSB +: LEN_W]  = len;
        word[PORT_LSB +: 3]     = meta.port;
        word[DA_LSB +: 2]       = meta.da;
        word[IPF_BIT]           = meta.ipf;
        word[VLAN_BIT]          = meta.vlan;
        word[1:0]               = meta.ptype;
    end
endmodule

// File: rtl/rxd_ring_writer.sv
// Receive descriptor ring writer (top).
// Per frame it:
//   - reads descriptor word 0 (owner, end-of-ring, buffer address);
//   - reads word 2 (length limit), then packs and stores frame bytes;
//   - writes status to word 3, then releases word 0.
// A frame that meets a CPU-owned descriptor is dropped and flagged.
// Assumes buffer addresses are word aligned and AW+2 <= 25.
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_addr,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          s_sof,
    input  logic          s_eof,
    input  logic [7:0]    s_data,
    input  logic [2:0]    s_port,
    input  logic [1:0]    s_da_class,
    input  logic          s_ip_bad,
    input  logic          s_vlan,
    input  logic [1:0]    s_ptype,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq_done,
    output logic          irq_nodesc
);
    localparam int BYTES = 4;
    localparam int CW    = $clog2(BYTES + 1);
    localparam logic [CW-1:0] LAST_LANE = CW'(BYTES - 1);

    wr_state_t        state_q, state_d;
    logic [31:0]      d0_q;
    logic [LEN_W-1:0] blen_q, len_q;
    rx_meta_t         meta_q;
    logic [AW-1:0]    wptr_q;
    logic             last_q, nodesc_q;

    logic [AW-1:0]    ring_ptr;
    logic [31:0]      pack_word, stat_word;
    logic [CW-1:0]    fill;
    logic             xfer, byte_take, byte_store, pack_full;

    assign xfer       = mem_req & mem_gnt;
    assign byte_take  = (state_q == ST_RECV) && s_valid;
    assign byte_store = byte_take && (len_q < blen_q);
    assign pack_full  = byte_store && (fill == LAST_LANE);

    rxd_ring #(.AW(AW), .STEP(DESC_WORDS)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (base_wr && state_q == ST_IDLE),
        .load_addr (base_addr),
        .step      (state_q == ST_DONE),
        .wrap      (d0_q[EOR_BIT]),
        .cur       (ring_ptr)
    );

    rxd_pack #(.BYTES(BYTES)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_WDAT && xfer),
        .push  (byte_store),
        .din   (s_data),
        .word  (pack_word),
        .fill  (fill)
    );

    rxd_status_enc u_stat (
        .len  (len_q),
        .meta (meta_q),
        .word (stat_word)
    );

    // Next-state selection for the per-frame sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (s_valid && s_sof) state_d = ST_RD0;
            ST_RD0:   if (xfer) state_d = ST_RD0W;
            ST_RD0W:  state_d = mem_rdata[OWN_BIT] ? ST_RD2 : ST_DROP;
            ST_RD2:   if (xfer) state_d = ST_RD2W;
            ST_RD2W:  state_d = ST_RECV;
            ST_RECV: begin
                if (byte_take) begin
                    if (pack_full || (s_eof && (fill != '0 || byte_store)))
                        state_d = ST_WDAT;
                    else if (s_eof)
                        state_d = ST_WSTAT;
                end
            end
            ST_WDAT:  if (xfer) state_d = last_q ? ST_WSTAT : ST_RECV;
            ST_WSTAT: if (xfer) state_d = ST_WOWN;
            ST_WOWN:  if (xfer) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_DROP:  if (s_valid && s_eof) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ring_ptr;
        mem_wdata = '0;
        case (state_q)
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = ring_ptr + AW'(OFS_BUF1);
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = ring_ptr + AW'(OFS_BLEN);
            end
            ST_WDAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr_q;
                mem_wdata = pack_word;
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ring_ptr + AW'(OFS_STAT);
                mem_wdata = stat_word;
            end
            ST_WOWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ring_ptr + AW'(OFS_BUF1);
                mem_wdata = d0_q & ~(32'h1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    assign s_ready    = (state_q == ST_RECV) || (state_q == ST_DROP);
    assign irq_done   = (state_q == ST_DONE);
    assign irq_nodesc = nodesc_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor word 0 capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                  d0_q <= '0;
        else if (state_q == ST_RD0W) d0_q <= mem_rdata;
    end

    // Length limit, stored length and end-of-frame tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
            len_q  <= '0;
            last_q <= 1'b0;
        end else if (state_q == ST_RD2W) begin
            blen_q <= mem_rdata[LEN_W-1:0];
            len_q  <= '0;
            last_q <= 1'b0;
        end else begin
            if (byte_store)           len_q  <= len_q + 1'b1;
            if (byte_take && s_eof)   last_q <= 1'b1;
        end
    end

    // Buffer word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wptr_q <= '0;
        else if (state_q == ST_RD2W)         wptr_q <= d0_q[AW+1:2];
        else if (state_q == ST_WDAT && xfer) wptr_q <= wptr_q + 1'b1;
    end

    // Metadata captured with the start-of-frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) meta_q <= '0;
        else if (byte_take && s_sof)
            meta_q <= '{port: s_port, da: s_da_class, ipf: s_ip_bad,
                        vlan: s_vlan, ptype: s_ptype};
    end

    // No-descriptor pulse, one cycle after a CPU-owned word 0 is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) nodesc_q <= 1'b0;
        else        nodesc_q <= (state_q == ST_RD0W) && !mem_rdata[OWN_BIT];
    end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
// Protocol checker for rxd_ring_writer, attached by bind.
// Observes top-level ports only.
module rxd_ring_writer_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          irq_done,
    input logic          irq_nodesc
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(mem_req && mem_gnt && mem_we));
    // R2
    nodesc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nodesc |=> !irq_nodesc);
    // R2
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done && irq_nodesc));
    // R4
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req);
    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !s_ready && !irq_done && !irq_nodesc));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .irq_done   (irq_done),
    .irq_nodesc (irq_nodesc)
);

// File: tb/rxd_ring_writer_test.sv
module rxd_ring_writer_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_wr = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
    logic [7:0]    s_data = '0;
    logic [2:0]    s_port = '0;
    logic [1:0]    s_da_class = '0, s_ptype = '0;
    logic          s_ip_bad = 1'b0, s_vlan = 1'b0;
    logic          s_ready, mem_req, mem_gnt, mem_we, irq_done, irq_nodesc;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    logic [31:0]   mem [0:(1<<AW)-1];
    logic          stall_mode = 1'b0;
    logic [7:0]    lfsr = 8'hA5;

    int errors = 0, checks = 0, ptr_m = 0;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0 write, 1 done, 2 nodesc
        int          a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    rxd_ring_writer #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
        .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_eof(s_eof),
        .s_data(s_data), .s_port(s_port), .s_da_class(s_da_class),
        .s_ip_bad(s_ip_bad), .s_vlan(s_vlan), .s_ptype(s_ptype),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_done(irq_done), .irq_nodesc(irq_nodesc)
    );

    // Memory model: grant withheld pseudo-randomly in stall mode (R10).
    assign mem_gnt = mem_req && !(stall_mode && lfsr[0]);
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 37) & 255);
    endfunction

    task automatic put_desc(input int at, input bit own, input bit eor,
                            input int buf_word, input int blen);
        mem[at]     = {own, 2'b00, eor, 3'b000, 25'(buf_word * 4)};
        mem[at + 1] = 32'h0;
        mem[at + 2] = 32'(blen);
        mem[at + 3] = 32'hDEAD_BEEF;
    endtask

    // Driver: queue expected events, then stream the frame.
    task automatic send(input int n, input int seed, input int port, input int da,
                        input bit ipf, input bit vlan, input int ptype,
                        input string rtag);
        logic [31:0] w0, wd;
        int blen, stored, nw;
        bit ok;
        w0 = mem[ptr_m];
        if (!w0[31]) begin
            sb.push_back('{2, 0, 32'h0, "R2"});
        end else begin
            blen = int'(mem[ptr_m + 2][10:0]);
            stored = (n < blen) ? n : blen;
            nw = (stored + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                wd = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < stored) wd[8*b +: 8] = pat(seed, w * 4 + b);
                sb.push_back('{0, int'(w0[24:0]) / 4 + w, wd, rtag});
            end
            sb.push_back('{0, ptr_m + 3,
                           (32'(stored) << 16) | (32'(port) << 12) | (32'(da) << 4) |
                           (32'(ipf) << 3) | (32'(vlan) << 2) | 32'(ptype), "R6"});
            sb.push_back('{0, ptr_m, w0 & 32'h7FFF_FFFF, "R1,R3"});
            sb.push_back('{1, 0, 32'h0, "R7"});
            ptr_m = w0[28] ? int'(base_addr) : ptr_m + 4;
        end
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1; s_data = pat(seed, i);
            s_sof = (i == 0); s_eof = (i == n - 1);
            s_port = 3'(port); s_da_class = 2'(da); s_ip_bad = ipf;
            s_vlan = vlan; s_ptype = 2'(ptype);
            forever begin
                ok = s_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic load_base(input int a);
        base_addr = AW'(a); base_wr = 1'b1;
        @(negedge clk);
        base_wr = 1'b0;
        ptr_m = a;
    endtask

    // Monitor: compare granted writes and pulses against the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && (irq_done || irq_nodesc || (mem_req && mem_gnt && mem_we))) begin
                if (sb.size() == 0) begin
                    check(0, "unexpected event", {irq_done, irq_nodesc, 6'b0, 24'(mem_addr)}, 0);
                end else begin
                    e = sb.pop_front();
                    if (e.kind == 0)
                        check(mem_we && mem_req && !irq_done && !irq_nodesc &&
                              int'(mem_addr) == e.a && mem_wdata === e.d,
                              $sformatf("%s write@%0d", e.tag, e.a), mem_wdata, e.d);
                    else if (e.kind == 1)
                        check(irq_done && !irq_nodesc, "R7 done pulse",
                              {30'b0, irq_done, irq_nodesc}, 32'h2);
                    else
                        check(irq_nodesc && !irq_done, "R2 nodesc pulse",
                              {30'b0, irq_done, irq_nodesc}, 32'h1);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R8 during and after reset
        check(!mem_req && !s_ready, "R8 in reset", {30'b0, mem_req, s_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !s_ready && !irq_done && !irq_nodesc, "R8 after reset",
              {28'b0, mem_req, s_ready, irq_done, irq_nodesc}, 0);

        // R9: relocate ring to word 16; three descriptors, last wraps.
        load_base(16);
        put_desc(16, 1, 0, 256, 1550);
        put_desc(20, 1, 0, 512, 1550);
        put_desc(24, 1, 1, 768, 1550);
        send(9, 3, 3, 1, 0, 1, 1, "R4,R9");
        stall_mode = 1'b1;
        send(64, 11, 5, 2, 1, 0, 0, "R4,R10");
        send(4, 90, 0, 3, 1, 1, 2, "R4");
        // R2: descriptor 16 was released, CPU owns it now.
        send(5, 7, 1, 0, 0, 0, 0, "R2");
        // Re-arm with a 6-byte limit; pointer must not have moved (R2, R5).
        put_desc(16, 1, 0, 256, 6);
        send(10, 50, 2, 1, 0, 0, 1, "R5");
        put_desc(20, 1, 0, 512, 8);
        send(8, 60, 4, 0, 1, 0, 0, "R5");
        put_desc(24, 1, 1, 768, 8);
        send(11, 70, 6, 2, 0, 1, 1, "R5");
        // R3: single-descriptor ring wraps onto itself.
        stall_mode = 1'b0;
        load_base(40);
        put_desc(40, 1, 1, 1024, 1550);
        send(3, 21, 7, 3, 1, 1, 0, "R3");
        put_desc(40, 1, 1, 1024, 1550);
        send(1, 99, 2, 0, 0, 0, 1, "R3");

        check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule